// File: doc/BRIEF.md
# Wrap-Around Product-Term Sharing Array

This block is the logic core of one logic block in a small programmable fabric. It takes 68 routed input signals and offers each one to every product term in both true and inverted form. It forms 160 logic product terms and groups them into 32 clusters of five consecutive terms. It also forms three additional control terms. Those control terms go to the logic block's shared reset, clock, clock-enable and output-enable circuits; they never enter the clusters.

Each of the 32 macrocell drivers can take its value from one of two paths:
- **Fast bypass.** The driver takes only its own cluster. This path serves functions of five terms or fewer.
- **Sharing ring.** The driver takes the OR of every cluster assigned to it. A cluster can be given to its own macrocell or to any of the six macrocells below it, and the numbering wraps from the last cluster back to the first. One function can therefore absorb seven clusters, which is 35 terms.

All configuration arrives as flat vectors that are loaded before operation. The outputs are purely combinational.

Top module: `pts_share_array`

## Requirements
- R1: Term t reads its literal selects from `and_cfg[t*136 +: 136]`. Bit 2i selects input i in true form and bit 2i+1 selects it in inverted form. The term is the AND of all the literals it selects.
- R2: A term that selects no literal is 0. A term that selects both polarities of the same input is also 0.
- R3: Cluster c is the OR of logic terms 5c through 5c+4.
- R4: Cluster c carries a 3-bit route field at `route_cfg[3c +: 3]`. A value d from 0 to 6 assigns the cluster to macrocell (c - d) mod 32. The shared sum of a macrocell is the OR of every cluster assigned to it.
- R5: Assignment wraps around the ring. For example, cluster 2 with d = 5 feeds macrocell 29.
- R6: Route value 7 marks a cluster as unshared, and that cluster feeds no shared sum.
- R7: When `bypass_cfg[m]` is 1, `mc_sum[m]` equals the sum of cluster m alone. Clusters assigned to macrocell m through the ring have no effect on it in that case.
- R8: A macrocell that collects its own cluster and the six clusters above it responds to any of those 35 terms.
- R9: Control terms 160, 161 and 162 drive `ctrl_term[0]`, `ctrl_term[1]` and `ctrl_term[2]` respectively, and do not reach any macrocell output.
- R10: The outputs follow the inputs and the configuration combinationally, with no clock and no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_sig | input | 68 | Routed input signals |
| and_cfg | input | 22168 | Literal selects, 136 bits for each of the 163 terms |
| route_cfg | input | 96 | Route field for each cluster, 3 bits per cluster |
| bypass_cfg | input | 32 | Per-macrocell selection of the bypass path |
| mc_sum | output | 32 | Sum-of-products value for each macrocell |
| ctrl_term | output | 3 | Control product terms for the block |

## Verification
The assertions assume that the configuration is fully defined and stays static while the routed inputs change. They also assume that every route field holds either a reach of 0 to 6 or the unshared code 7. Because the 3-bit field has no other encodings, the stimulus stays within these assumptions automatically. The random configurations select at most three literals per term, so that terms fire often enough to exercise the OR paths. The directed cases then set up wrap-around, full seven-cluster reach, bypass over assigned clusters, and conflicting polarities.

// File: rtl/pts_pkg.sv
// Shared sizing constants for the product-term sharing array.
// Assumes one logic block per instance; all derived widths come from here.
package pts_pkg;
    localparam int unsigned PTS_NUM_IN      = 68;
    localparam int unsigned PTS_NUM_CLUSTER = 32;
    localparam int unsigned PTS_CLUSTER_SZ  = 5;
    localparam int unsigned PTS_REACH       = 6;
    localparam int unsigned PTS_NUM_CTRL    = 3;
endpackage

// File: rtl/pts_term_array.sv
// Programmable AND plane: forms NUM_TERMS product terms from the true and
// inverted forms of NUM_IN inputs. Assumes and_cfg is static in operation.
module pts_term_array #(
    parameter int unsigned NUM_IN    = 68,
    parameter int unsigned NUM_TERMS = 163,
    localparam int unsigned LIT_W    = 2 * NUM_IN
) (
    input  logic [NUM_IN-1:0]          in_sig,
    input  logic [NUM_TERMS*LIT_W-1:0] and_cfg,
    output logic [NUM_TERMS-1:0]       prod
);
    logic [LIT_W-1:0] lit;

    // Build the literal bus: even bit true form, odd bit inverted form.
    always_comb begin
        for (int i = 0; i < int'(NUM_IN); i++) begin
            lit[2*i]   = in_sig[i];
            lit[2*i+1] = ~in_sig[i];
        end
    end

    generate
        for (genvar t = 0; t < int'(NUM_TERMS); t++) begin : g_term
            logic [LIT_W-1:0] sel;
            assign sel = and_cfg[t*LIT_W +: LIT_W];
            // Term is high only if it selects something and every selected literal is high.
            assign prod[t] = (|sel) & (&(lit | ~sel));
        end
    endgenerate
endmodule

// File: rtl/pts_cluster_or.sv
// Groups logic terms into clusters of CLUSTER_SZ consecutive terms and ORs
// each cluster. Assumes prod holds only logic terms, lowest term first.
module pts_cluster_or #(
    parameter int unsigned NUM_CLUSTER = 32,
    parameter int unsigned CLUSTER_SZ  = 5
) (
    input  logic [NUM_CLUSTER*CLUSTER_SZ-1:0] prod,
    output logic [NUM_CLUSTER-1:0]            cl_sum
);
    generate
        for (genvar c = 0; c < int'(NUM_CLUSTER); c++) begin : g_cl
            logic [CLUSTER_SZ-1:0] grp;
            assign grp = prod[c*CLUSTER_SZ +: CLUSTER_SZ];
            // Cluster sum is the OR of its own terms.
            assign cl_sum[c] = |grp;

            // Check that the cluster sum agrees with the count of active terms in it.
            always_comb begin
                a_r3_cluster_or : assert (cl_sum[c] == ($countones(grp) != 0))
                    else $error("R3 cluster %0d sum mismatch", c);
            end
        end
    endgenerate
endmodule

// File: rtl/pts_share_ring.sv
// Steers cluster sums to macrocells. Each macrocell collects the clusters
// at ring distance 0..REACH above it whose route field names that distance,
// or takes its own cluster alone when bypassed. Field value (2**SEL_W)-1
// marks an unshared cluster; assumes REACH < (2**SEL_W)-1.
module pts_share_ring #(
    parameter int unsigned NUM_CLUSTER = 32,
    parameter int unsigned REACH       = 6,
    localparam int unsigned SEL_W      = $clog2(REACH + 2)
) (
    input  logic [NUM_CLUSTER-1:0]       cl_sum,
    input  logic [NUM_CLUSTER*SEL_W-1:0] route_cfg,
    input  logic [NUM_CLUSTER-1:0]       bypass_cfg,
    output logic [NUM_CLUSTER-1:0]       mc_sum,
    output logic [NUM_CLUSTER-1:0]       shared_sum
);
    generate
        for (genvar m = 0; m < int'(NUM_CLUSTER); m++) begin : g_mc
            logic [REACH:0] hit;
            for (genvar d = 0; d <= int'(REACH); d++) begin : g_reach
                localparam int unsigned SRC = (m + d) % NUM_CLUSTER;
                // A cluster contributes when its route field names this distance.
                assign hit[d] = cl_sum[SRC] &
                    (route_cfg[SRC*SEL_W +: SEL_W] == SEL_W'(d));
            end
            // Shared sum gathers all assigned clusters in the window.
            assign shared_sum[m] = |hit;
            // Bypass selects the macrocell's own cluster directly.
            assign mc_sum[m] = bypass_cfg[m] ? cl_sum[m] : shared_sum[m];
        end
    endgenerate
endmodule

// File: rtl/pts_share_array.sv
// Top of the product-term sharing array for one logic block: AND plane,
// cluster ORs, wrap-around sharing ring and control terms. Purely
// combinational; assumes configuration is loaded before inputs are used.
module pts_share_array
    import pts_pkg::*;
#(
    parameter int unsigned NUM_IN      = PTS_NUM_IN,
    parameter int unsigned NUM_CLUSTER = PTS_NUM_CLUSTER,
    parameter int unsigned CLUSTER_SZ  = PTS_CLUSTER_SZ,
    parameter int unsigned REACH       = PTS_REACH,
    parameter int unsigned NUM_CTRL    = PTS_NUM_CTRL,
    localparam int unsigned LIT_W      = 2 * NUM_IN,
    localparam int unsigned NUM_LOGIC  = NUM_CLUSTER * CLUSTER_SZ,
    localparam int unsigned NUM_TERMS  = NUM_LOGIC + NUM_CTRL,
    localparam int unsigned SEL_W      = $clog2(REACH + 2)
) (
    input  logic [NUM_IN-1:0]            in_sig,
    input  logic [NUM_TERMS*LIT_W-1:0]   and_cfg,
    input  logic [NUM_CLUSTER*SEL_W-1:0] route_cfg,
    input  logic [NUM_CLUSTER-1:0]       bypass_cfg,
    output logic [NUM_CLUSTER-1:0]       mc_sum,
    output logic [NUM_CTRL-1:0]          ctrl_term
);
    logic [NUM_TERMS-1:0]   prod;
    logic [NUM_CLUSTER-1:0] cl_sum;
    logic [NUM_CLUSTER-1:0] shared_sum;

    pts_term_array #(
        .NUM_IN    (NUM_IN),
        .NUM_TERMS (NUM_TERMS)
    ) u_terms (
        .in_sig  (in_sig),
        .and_cfg (and_cfg),
        .prod    (prod)
    );

    pts_cluster_or #(
        .NUM_CLUSTER (NUM_CLUSTER),
        .CLUSTER_SZ  (CLUSTER_SZ)
    ) u_clusters (
        .prod   (prod[NUM_LOGIC-1:0]),
        .cl_sum (cl_sum)
    );

    pts_share_ring #(
        .NUM_CLUSTER (NUM_CLUSTER),
        .REACH       (REACH)
    ) u_ring (
        .cl_sum     (cl_sum),
        .route_cfg  (route_cfg),
        .bypass_cfg (bypass_cfg),
        .mc_sum     (mc_sum),
        .shared_sum (shared_sum)
    );

    // Control terms sit above the logic terms and bypass the clusters.
    assign ctrl_term = prod[NUM_TERMS-1 -: NUM_CTRL];

    // Cross-module checks between the plane, ring and outputs.
    always_comb begin
        for (int k = 0; k < int'(NUM_CTRL); k++) begin
            if (and_cfg[(NUM_LOGIC+k)*LIT_W +: LIT_W] == '0) begin
                a_r2_blank_ctrl_low : assert (ctrl_term[k] == 1'b0)
                    else $error("R2 blank control term %0d high", k);
            end
        end
        for (int m = 0; m < int'(NUM_CLUSTER); m++) begin
            if (bypass_cfg[m]) begin
                a_r7_bypass_own : assert (mc_sum[m] == cl_sum[m])
                    else $error("R7 bypass macrocell %0d", m);
            end else begin
                a_r4_shared_drives : assert (mc_sum[m] == shared_sum[m])
                    else $error("R4 shared macrocell %0d", m);
            end
        end
        for (int c = 0; c < int'(NUM_CLUSTER); c++) begin
            if (route_cfg[c*SEL_W +: SEL_W] <= SEL_W'(REACH)) begin
                if (cl_sum[c] && !bypass_cfg[(c + NUM_CLUSTER -
                        int'(route_cfg[c*SEL_W +: SEL_W])) % NUM_CLUSTER]) begin
                    a_r5_wrap_reach : assert (mc_sum[(c + NUM_CLUSTER -
                        int'(route_cfg[c*SEL_W +: SEL_W])) % NUM_CLUSTER])
                        else $error("R5 cluster %0d lost", c);
                end
            end
        end
    end
endmodule

// File: tb/pts_share_array_test.sv
// Bench for the sharing array: seeded random configurations walked from a
// table and compared with a list-based model, then directed corner cases.
module pts_share_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 68, NC = 32, CS = 5, NT = 163, LW = 136, NL = 160;
    localparam int NSEED = 8;
    localparam logic [31:0] SEED_TAB [NSEED] = '{
        32'h1234_5678, 32'hCAFE_0001, 32'h0BAD_F00D, 32'h7777_1111,
        32'hDEAD_0042, 32'h0F0F_F0F0, 32'h1357_9BDF, 32'h2468_ACE0};

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NI-1:0]    in_sig = '0;
    logic [NT*LW-1:0] and_cfg = '0;
    logic [NC*3-1:0]  route_cfg = {NC{3'd7}};
    logic [NC-1:0]    bypass_cfg = '0;
    logic [NC-1:0]    mc_sum;
    logic [2:0]       ctrl_term;

    pts_share_array uut (
        .in_sig(in_sig), .and_cfg(and_cfg), .route_cfg(route_cfg),
        .bypass_cfg(bypass_cfg), .mc_sum(mc_sum), .ctrl_term(ctrl_term));

    int errors = 0, checks = 0;
    bit done = 0;
    logic [31:0] rng;
    int lit_n [NT];
    int lit_idx [NT][3];
    bit lit_pol [NT][3];
    int rfield [NC];

    function automatic logic [31:0] next_rand(logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic roll(output int v, input int mod);
        rng = next_rand(rng);
        v = int'(rng % mod);
    endtask

    task automatic clear_cfg();
        for (int t = 0; t < NT; t++) lit_n[t] = 0;
        for (int c = 0; c < NC; c++) rfield[c] = 7;
        bypass_cfg = '0;
    endtask

    task automatic add_lit(int t, int idx, bit pol);
        lit_idx[t][lit_n[t]] = idx;
        lit_pol[t][lit_n[t]] = pol;
        lit_n[t]++;
    endtask

    // Pack the list form into the flat vectors (R1, R4 encodings).
    task automatic pack_cfg();
        and_cfg = '0;
        for (int t = 0; t < NT; t++)
            for (int k = 0; k < lit_n[t]; k++)
                and_cfg[t*LW + 2*lit_idx[t][k] + int'(lit_pol[t][k])] = 1'b1;
        for (int c = 0; c < NC; c++) route_cfg[c*3 +: 3] = 3'(rfield[c]);
    endtask

    function automatic bit m_term(int t);
        bit v = (lit_n[t] != 0);
        for (int k = 0; k < lit_n[t]; k++)
            v &= in_sig[lit_idx[t][k]] ^ lit_pol[t][k];
        return v;
    endfunction

    function automatic bit m_cluster(int c);
        bit v = 0;
        for (int j = 0; j < CS; j++) v |= m_term(c*CS + j);
        return v;
    endfunction

    function automatic logic [NC-1:0] m_mc();
        logic [NC-1:0] r = '0;
        for (int m = 0; m < NC; m++) begin
            if (bypass_cfg[m]) r[m] = m_cluster(m);
            else
                for (int c = 0; c < NC; c++)
                    if (rfield[c] != 7 && ((c - rfield[c] + NC) % NC) == m)
                        r[m] |= m_cluster(c);
        end
        return r;
    endfunction

    function automatic logic [2:0] m_ctrl();
        logic [2:0] r;
        for (int k = 0; k < 3; k++) r[k] = m_term(NL + k);
        return r;
    endfunction

    task automatic chk_mc(string req, logic [NC-1:0] exp);
        checks++;
        if (mc_sum !== exp) begin
            errors++;
            $display("FAIL %s mc_sum actual=%h expected=%h", req, mc_sum, exp);
        end
    endtask

    task automatic chk_ctrl(string req, logic [2:0] exp);
        checks++;
        if (ctrl_term !== exp) begin
            errors++;
            $display("FAIL %s ctrl_term actual=%b expected=%b", req, ctrl_term, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        // Idle state: blank configuration gives all-low outputs (R2).
        clear_cfg(); pack_cfg();
        in_sig = {NI{1'b1}};
        settle();
        chk_mc("R2 blank config", '0);
        chk_ctrl("R2 blank ctrl", 3'b000);

        // Table walk: random configurations against the model (R1 R3 R4 R6 R7 R9).
        for (int s = 0; s < NSEED; s++) begin
            rng = SEED_TAB[s];
            clear_cfg();
            for (int t = 0; t < NT; t++) begin
                int n;
                roll(n, 4);
                for (int k = 0; k < n; k++) begin
                    int idx, pol;
                    roll(idx, NI); roll(pol, 2);
                    add_lit(t, idx, bit'(pol));
                end
            end
            for (int c = 0; c < NC; c++) roll(rfield[c], 8);
            rng = next_rand(rng);
            bypass_cfg = rng & (s[0] ? 32'h0F0F_00FF : 32'h0000_0000);
            pack_cfg();
            for (int vct = 0; vct < 6; vct++) begin
                rng = next_rand(rng); in_sig[31:0] = rng;
                rng = next_rand(rng); in_sig[63:32] = rng;
                rng = next_rand(rng); in_sig[67:64] = rng[3:0];
                settle();
                chk_mc("R4 random sum-of-products", m_mc());
                chk_ctrl("R9 random control terms", m_ctrl());
            end
        end

        // R1: true polarity of input 5 in term 0, cluster 0 to macrocell 0.
        clear_cfg(); add_lit(0, 5, 0); rfield[0] = 0; pack_cfg();
        in_sig = '0; in_sig[5] = 1'b1; settle();
        chk_mc("R1 true literal high", 32'h1);
        in_sig[5] = 1'b0; settle();
        chk_mc("R1 true literal low", 32'h0);
        // R1: inverted polarity.
        clear_cfg(); add_lit(1, 9, 1); rfield[0] = 0; pack_cfg();
        in_sig = '0; settle();
        chk_mc("R1 inverted literal", 32'h1);
        // R2: both polarities of one input never fire.
        clear_cfg(); add_lit(2, 3, 0); add_lit(2, 3, 1); rfield[0] = 0; pack_cfg();
        in_sig = '0; settle(); chk_mc("R2 conflicting literals low input", 32'h0);
        in_sig[3] = 1'b1; settle(); chk_mc("R2 conflicting literals high input", 32'h0);
        // R5: cluster 2 reach 5 wraps to macrocell 29.
        clear_cfg(); add_lit(10, 0, 0); rfield[2] = 5; pack_cfg();
        in_sig = '0; in_sig[0] = 1'b1; settle();
        chk_mc("R5 wrap to macrocell 29", 32'h2000_0000);
        // R6: unshared cluster feeds nothing even when its term fires.
        rfield[2] = 7; pack_cfg(); settle();
        chk_mc("R6 unshared cluster", 32'h0);
        // R7: bypass on macrocell 3 ignores cluster 4 assigned to it.
        clear_cfg(); add_lit(20, 0, 0); rfield[4] = 1; pack_cfg();
        in_sig = '0; in_sig[0] = 1'b1; settle();
        chk_mc("R7 shared before bypass", 32'h8);
        bypass_cfg[3] = 1'b1; settle();
        chk_mc("R7 bypass ignores shared cluster", 32'h0);
        add_lit(15, 1, 0); pack_cfg(); in_sig[1] = 1'b1; settle();
        chk_mc("R7 bypass own cluster", 32'h8);
        // R8: macrocell 10 collects clusters 10..16, last term 84 fires.
        clear_cfg(); add_lit(84, 7, 0); add_lit(50, 8, 0);
        for (int c = 10; c <= 16; c++) rfield[c] = c - 10;
        pack_cfg(); in_sig = '0; in_sig[7] = 1'b1; settle();
        chk_mc("R8 term 84 at reach 6", 32'h400);
        in_sig = '0; in_sig[8] = 1'b1; settle();
        chk_mc("R8 term 50 at reach 0", 32'h400);
        // R9: control terms stay out of macrocells.
        clear_cfg(); add_lit(160, 2, 0); add_lit(162, 4, 1);
        for (int c = 0; c < NC; c++) rfield[c] = 0;
        pack_cfg(); in_sig = '0; in_sig[2] = 1'b1; settle();
        chk_ctrl("R9 control terms", 3'b101);
        chk_mc("R9 control terms isolated", 32'h0);
        // R10: output follows input with no clock edge in between.
        in_sig[4] = 1'b1; #1;
        chk_ctrl("R10 combinational update", 3'b001);
        v = 0;
        finish_run();
    end
endmodule